// File: doc/BRIEF.md
# Field-Masked BCD Alarm Match Unit

This unit compares a running calendar time, delivered by an external counter chain as six BCD fields, against six programmable alarm registers. It covers seconds, minutes, hours, day of week, day of month and month. Each alarm register carries its own compare-enable bit, so software can choose any subset of fields to take part in the match. One example is "every hour at minute 30". Another is "month 12, day 31, 23:59:59".

On the counter tick where all enabled fields first equal the current time, the unit sets a sticky alarm flag. The flag stays set until software writes 0 to it. The interrupt output is the flag gated by an interrupt-enable bit. Software reaches the alarm registers and the control register through a simple write port and a separate combinational read port.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, all six alarm registers read 0x00, the control register reads 0x00 and `irq` is 0.
- R2: Register addresses are: 8 = second alarm, 9 = minute alarm, 10 = hour alarm, 11 = weekday alarm, 12 = day alarm, 13 = month alarm, and 14 = control. A written alarm register reads back all 8 bits. The control register reads bit 0 = alarm flag and bit 3 = interrupt enable, and all other bits read 0.
- R3: In an alarm register, bit 7 is the compare enable and bits 6:0 are the BCD value. A field whose enable is 0 is ignored, whatever the current time holds for it.
- R4: The flag sets only on a cycle with `tick` high, when every enabled field equals its time input and the previous tick did not match. Without `tick`, a matching time does not set the flag.
- R5: With no field enabled, the flag never sets.
- R6: The flag is sticky. While the match persists across further ticks it does not set again after being cleared. After a non-matching tick, a new match sets it again.
- R7: Writing the control register with bit 0 = 0 clears the flag, and bit 0 = 1 leaves it unchanged. If a set and a clear fall on the same cycle, the flag ends set.
- R8: `irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R9: The month alarm takes BCD 0x01 to 0x12. A month of 0x12 matches the time input 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse; time inputs are valid and newly counted |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD |
| now_wday | input | 7 | Current day of week, BCD |
| now_day | input | 7 | Current day of month, BCD |
| now_mon | input | 7 | Current month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The bound assertions watch, on every cycle, these properties:
- the flag rises only right after a tick;
- the flag never rises while all enables are clear;
- the flag holds unless a clearing write arrives, and a clearing write without a tick drops it;
- the interrupt never appears without the flag.

Field masking, the edge-only set that refuses to retrigger on a persisting match, set-over-clear priority and readback values need the bench's scenarios. There, directed cases are mixed with seeded random times and enable masks, and all are checked against a reference model.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int AW   = 4,
  parameter int BASE = 8,
  parameter int CTRL = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [6:0]    now_sec,
  input  logic [6:0]    now_min,
  input  logic [6:0]    now_hour,
  input  logic [6:0]    now_wday,
  input  logic [6:0]    now_day,
  input  logic [6:0]    now_mon,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          irq
);
  localparam int NF       = 6;
  localparam int EN_BIT   = 7;
  localparam int FLAG_BIT = 0;
  localparam int IE_BIT   = 3;

  logic [NF-1:0][7:0] alm;
  logic [NF-1:0][6:0] now_v;
  logic [NF-1:0]      fld_ok;
  logic [NF-1:0]      fld_en;
  logic               any_en, hit, prev_hit, set_ev, clr_wr, ctrl_wr;
  logic               flag, aie;

  assign now_v = {now_mon, now_day, now_wday, now_hour, now_min, now_sec};

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign fld_en[i] = alm[i][EN_BIT];
    assign fld_ok[i] = !fld_en[i] || (alm[i][6:0] == now_v[i]);
  end

  assign any_en  = |fld_en;
  assign hit     = any_en && (&fld_ok);
  assign set_ev  = tick && hit && !prev_hit;
  assign ctrl_wr = wr_en && (wr_addr == AW'(CTRL));
  assign clr_wr  = ctrl_wr && !wr_data[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm      <= '0;
      aie      <= 1'b0;
      flag     <= 1'b0;
      prev_hit <= 1'b0;
    end else begin
      for (int i = 0; i < NF; i++)
        if (wr_en && wr_addr == AW'(BASE + i)) alm[i] <= wr_data;
      if (ctrl_wr) aie <= wr_data[IE_BIT];
      if (tick) prev_hit <= hit;
      flag <= set_ev || (flag && !clr_wr);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NF; i++)
      if (rd_addr == AW'(BASE + i)) rd_data = alm[i];
    if (rd_addr == AW'(CTRL)) begin
      rd_data[FLAG_BIT] = flag;
      rd_data[IE_BIT]   = aie;
    end
  end

  assign irq = flag && aie;
endmodule

module rtc_alarm_match_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic any_en,
  input logic flag,
  input logic clr_wr,
  input logic irq
);
  a_r4_set_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));
  a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(any_en));
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !tick) |=> !flag);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .any_en(any_en),
  .flag(flag), .clr_wr(clr_wr), .irq(irq)
);

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;
  logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [6:0] n_sec = 0, n_min = 0, n_hour = 0, n_wday = 0, n_day = 0, n_mon = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0, fails = 0;

  logic [7:0] m_alm [6];
  logic       m_flag = 0, m_aie = 0, m_prev = 0;

  always #5 clk = ~clk;

  rtc_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .now_sec(n_sec), .now_min(n_min), .now_hour(n_hour),
    .now_wday(n_wday), .now_day(n_day), .now_mon(n_mon),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [6:0] bcd(input int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic model_hit();
    logic [6:0] nv [6];
    logic any = 0, ok = 1;
    nv = '{n_sec, n_min, n_hour, n_wday, n_day, n_mon};
    for (int i = 0; i < 6; i++)
      if (m_alm[i][7]) begin
        any = 1;
        if (m_alm[i][6:0] != nv[i]) ok = 0;
      end
    return any && ok;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic we, input int a, input logic [7:0] d,
                     input string tag);
    logic h, s, c;
    @(negedge clk);
    tick = tk; wr_en = we; wr_addr = 4'(a); wr_data = d;
    @(posedge clk);
    h = model_hit();
    s = tk && h && !m_prev;
    if (tk) m_prev = h;
    c = we && a == 14 && !d[0];
    m_flag = s ? 1'b1 : (c ? 1'b0 : m_flag);
    if (we && a == 14) m_aie = d[3];
    if (we && a >= 8 && a <= 13) m_alm[a-8] = d;
    #1;
    tick = 0; wr_en = 0;
    rd_addr = 4'd14;
    #1;
    chk(rd_data == {4'b0, m_aie, 2'b0, m_flag}, tag, rd_data, {4'b0, m_aie, 2'b0, m_flag});
    chk(irq == (m_flag && m_aie), {tag, "/R8"}, irq, m_flag && m_aie);
  endtask

  task automatic set_now(input int s, input int mi, input int h, input int w,
                         input int dy, input int mo);
    n_sec = bcd(s); n_min = bcd(mi); n_hour = bcd(h);
    n_wday = bcd(w); n_day = bcd(dy); n_mon = bcd(mo);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    for (int i = 0; i < 6; i++) m_alm[i] = 0;
    repeat (3) @(posedge clk);
    #2;
    for (int a = 8; a <= 14; a++) begin
      rd_addr = 4'(a); #1;
      chk(rd_data == 8'h00, "R1 reset reg", rd_data, 0);
    end
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    @(negedge clk); rst_n = 1;

    // R2 readback of each alarm register
    for (int a = 8; a <= 13; a++) begin
      cyc(0, 1, a, 8'(8'h15 + a), "R2");
      rd_addr = 4'(a); #1;
      chk(rd_data == 8'(8'h15 + a), "R2 alarm readback", rd_data, 8'h15 + a);
    end
    // R2/R7 control: other bits read 0, writing 1 to flag does not set it
    cyc(0, 1, 14, 8'hF7, "R7 write1 no set");
    cyc(0, 1, 14, 8'h00, "R2");

    // R5 no enabled field: bits 7 clear everywhere
    for (int a = 8; a <= 13; a++) cyc(0, 1, a, 8'h00, "R5");
    set_now(0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, "R5 no field enabled");
    cyc(1, 0, 0, 0, "R5 no field enabled");

    // R3 only minute enabled at 30; others hold mismatching values
    cyc(0, 1, 8, 8'h05, "R3");
    cyc(0, 1, 9, {1'b1, bcd(30)}, "R3");
    cyc(0, 1, 10, 8'h11, "R3");
    set_now(40, 30, 7, 2, 9, 4);
    cyc(0, 0, 0, 0, "R4 no tick no set");
    cyc(1, 0, 0, 0, "R3 masked fields ignored");
    // R6 match persists: clear, then further matching ticks do not retrigger
    cyc(0, 1, 14, 8'h00, "R7 clear");
    set_now(41, 30, 7, 2, 9, 4);
    cyc(1, 0, 0, 0, "R6 no retrigger");
    set_now(0, 31, 7, 2, 9, 4);
    cyc(1, 0, 0, 0, "R6 mismatch tick");
    set_now(0, 30, 8, 2, 9, 4);
    cyc(1, 0, 0, 0, "R6 rematch sets");
    // R7 simultaneous set and clear: set wins
    cyc(0, 1, 14, 8'h00, "R7 clear");
    set_now(0, 31, 8, 2, 9, 4);
    cyc(1, 0, 0, 0, "R7 prep");
    set_now(0, 30, 8, 2, 9, 4);
    cyc(1, 1, 14, 8'h00, "R7 set beats clear");
    // R8 enable gates irq
    cyc(0, 1, 14, 8'h09, "R8 irq on");
    cyc(0, 1, 14, 8'h01, "R8 irq off");
    cyc(0, 1, 14, 8'h00, "R7 clear");

    // R9 month 12 with full date
    cyc(0, 1, 8,  {1'b1, bcd(59)}, "R9");
    cyc(0, 1, 9,  {1'b1, bcd(59)}, "R9");
    cyc(0, 1, 10, {1'b1, bcd(23)}, "R9");
    cyc(0, 1, 12, {1'b1, bcd(31)}, "R9");
    cyc(0, 1, 13, {1'b1, bcd(12)}, "R9");
    set_now(59, 59, 23, 3, 31, 11);
    cyc(1, 0, 0, 0, "R9 month differs");
    set_now(59, 59, 23, 3, 31, 12);
    cyc(1, 0, 0, 0, "R9 month 12 matches");
    cyc(0, 1, 14, 8'h08, "R7 clear");

    // Random phase
    for (int it = 0; it < 600; it++) begin
      logic [6:0] v [6];
      if ($urandom_range(0, 7) == 0) begin
        int f = $urandom_range(0, 5);
        int val = (f == 5) ? $urandom_range(1, 12) : $urandom_range(0, 3);
        cyc(0, 1, 8 + f, {1'($urandom_range(0, 1)), bcd(val)}, "R3 rnd prog");
      end
      for (int f = 0; f < 6; f++)
        v[f] = ($urandom_range(0, 3) != 0) ? m_alm[f][6:0] : bcd($urandom_range(0, 3));
      n_sec = v[0]; n_min = v[1]; n_hour = v[2];
      n_wday = v[3]; n_day = v[4]; n_mon = v[5];
      case ($urandom_range(0, 5))
        0: cyc(1, 1, 14, {4'b0, 1'($urandom_range(0, 1)), 2'b0, 1'($urandom_range(0, 1))}, "R7 rnd");
        1: cyc(0, 0, 0, 0, "R4 rnd idle");
        default: cyc(1, 0, 0, 0, "R4 rnd tick");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule